// File: doc/BRIEF.md
# Host Controller Interrupt Status Register

This block keeps the sticky interrupt status flags of a USB host controller. The controller core reports events as one-cycle strobes (schedule overrun, done-queue writeback, frame start, system error, frame-number wrap, root-port change, ownership change) and as a level for device resume signalling. Each event latches a status flag that stays set until software writes a 1 to that flag's position.

Several flags also act back on the controller. A pending done-queue writeback flag withdraws the permission for further done-head writebacks. A system error raises a halt line that only a reset removes. Each frame start also produces a token request strobe. Each schedule overrun also steps a small wrapping counter.

A registered interrupt line combines the flags with a per-flag enable mask and a master enable. Software reaches the status, enable and counter words through a simple word-addressed bus. Read data is registered.

Top module: `hc_irq_status`

## Requirements
- R1: After reset every readable word is 0, irq is 0, writeback_permit is 1, ctrl_halt is 0 and sof_token_req is 0.
- R2: Word offsets are 0 for status, 1 for enable and 2 for the overrun count; offset 3 reads 0. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R3: When a set event and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R4: ev_sched_overrun sets status bit 0 and steps a 2-bit wrapping counter, which reads in bits [1:0] at offset 2.
- R5: ev_frame_start sets status bit 2. sof_token_req is high for exactly the one cycle that follows the event, which is the same cycle the bit first reads as set.
- R6: ev_donehead_written sets status bit 1. writeback_permit is low from the cycle after that event until the cycle after software clears the bit.
- R7: Status bit 3 sets only on a 0-to-1 change of dev_resume_sig while sw_resume_active is low in that cycle. A held high level, or a rise that happens during a software resume, does not set it.
- R8: ev_sys_error sets status bit 4 and raises ctrl_halt. ctrl_halt stays high until rst, even after software clears bit 4.
- R9: The enable word implements bits 0-6 and 30 as per-flag enables and bit 31 as a master enable; other enable bits read 0. irq is registered: one cycle after the enables and flags it is 1 exactly when the master enable is 1 and some status bit is 1 with its enable bit also 1.
- R10: ev_frame_wrap sets status bit 5, ev_port_change sets bit 6 and ev_owner_change sets bit 30. Every other status bit reads 0.
- R11: bus_rdata holds the word that bus_addr selected at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_sched_overrun | input | 1 | Frame schedule overran |
| ev_donehead_written | input | 1 | Done head copied to shared memory |
| ev_frame_start | input | 1 | New frame begins |
| dev_resume_sig | input | 1 | Device resume signalling level |
| sw_resume_active | input | 1 | Software-commanded resume state |
| ev_sys_error | input | 1 | Non-USB system error |
| ev_frame_wrap | input | 1 | Frame number overflow |
| ev_port_change | input | 1 | Root port status change |
| ev_owner_change | input | 1 | Ownership change |
| sched_overrun_cnt | output | 2 | Overrun counter value |
| writeback_permit | output | 1 | Done-head writeback allowed |
| sof_token_req | output | 1 | Start-of-frame token request |
| ctrl_halt | output | 1 | Stop all processing |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds dev_resume_sig high across a clear and across a software resume. A detector that reacts to the level would set the resume flag again, and one that ignores sw_resume_active would set it during the software resume. It issues a write-1 clear in the same cycle as a frame-start event, where a design that gives the clear priority would drop the flag. It checks that writeback permission returns only after the clear, that the halt line survives a clear of the error flag, that the counter wraps from 3 to 0, and that irq follows the master enable with the one-cycle register delay.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int CNT_W    = 2;

  // status bit positions (decoded by software)
  localparam int B_OVERRUN   = 0;
  localparam int B_DONEWB    = 1;
  localparam int B_FRAME     = 2;
  localparam int B_RESUME    = 3;
  localparam int B_SYSERR    = 4;
  localparam int B_FRAMEWRAP = 5;
  localparam int B_PORTCHG   = 6;
  localparam int B_OWNER     = 30;
  localparam int B_MASTER    = 31;

  localparam logic [DATA_W-1:0] STAT_MASK =
    (DATA_W'(1) << B_OVERRUN)   | (DATA_W'(1) << B_DONEWB)  |
    (DATA_W'(1) << B_FRAME)     | (DATA_W'(1) << B_RESUME)  |
    (DATA_W'(1) << B_SYSERR)    | (DATA_W'(1) << B_FRAMEWRAP) |
    (DATA_W'(1) << B_PORTCHG)   | (DATA_W'(1) << B_OWNER);
  localparam logic [DATA_W-1:0] EN_MASK = STAT_MASK | (DATA_W'(1) << B_MASTER);

  localparam int OFS_STATUS = 0;
  localparam int OFS_ENABLE = 1;
  localparam int OFS_COUNT  = 2;
endpackage

// File: rtl/hc_irq_sticky.sv
module hc_irq_sticky #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic b;
      always_ff @(posedge clk) begin
        if (rst)           b <= 1'b0;
        else if (set_i[i]) b <= 1'b1;   // event beats clear
        else if (clr_i[i]) b <= 1'b0;
      end
      assign q_o[i] = b;

      a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i[i] |=> b) else $error("R3 set lost");
      a_r2_w1c: assert property (@(posedge clk) disable iff (rst)
        (clr_i[i] && !set_i[i]) |=> !b) else $error("R2 clear ignored");
    end else begin : g_rsvd
      logic unused_b;
      assign unused_b = set_i[i] ^ clr_i[i];
      assign q_o[i]   = 1'b0;
    end
  end
endmodule

// File: rtl/hc_irq_resume_edge.sv
module hc_irq_resume_edge (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic sw_i,
  output logic rise_o
);
  logic prev_q;
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= line_i;
  end
  assign rise_o = line_i & ~prev_q & ~sw_i;
endmodule

// File: rtl/hc_irq_wrap_cnt.sv
module hc_irq_wrap_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end
  assign cnt_o = cnt_q;

  a_r4_cnt_step: assert property (@(posedge clk) disable iff (rst)
    inc_i |=> (cnt_q == W'($past(cnt_q) + W'(1)))) else $error("R4 count step");
  a_r4_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    !inc_i |=> $stable(cnt_q)) else $error("R4 count drift");
endmodule

// File: rtl/hc_irq_status.sv
module hc_irq_status
  import hc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_sched_overrun,
  input  logic              ev_donehead_written,
  input  logic              ev_frame_start,
  input  logic              dev_resume_sig,
  input  logic              sw_resume_active,
  input  logic              ev_sys_error,
  input  logic              ev_frame_wrap,
  input  logic              ev_port_change,
  input  logic              ev_owner_change,
  output logic [CNT_W-1:0]  sched_overrun_cnt,
  output logic              writeback_permit,
  output logic              sof_token_req,
  output logic              ctrl_halt,
  output logic              irq
);
  logic              resume_rise;
  logic [DATA_W-1:0] set_vec, clr_vec, status;
  logic [DATA_W-1:0] en_q, rdata_q;
  logic              halt_q, sof_q, irq_q;
  logic              wr_status, wr_enable;

  hc_irq_resume_edge u_resume (
    .clk(clk), .rst(rst), .line_i(dev_resume_sig),
    .sw_i(sw_resume_active), .rise_o(resume_rise)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[B_OVERRUN]   = ev_sched_overrun;
    set_vec[B_DONEWB]    = ev_donehead_written;
    set_vec[B_FRAME]     = ev_frame_start;
    set_vec[B_RESUME]    = resume_rise;
    set_vec[B_SYSERR]    = ev_sys_error;
    set_vec[B_FRAMEWRAP] = ev_frame_wrap;
    set_vec[B_PORTCHG]   = ev_port_change;
    set_vec[B_OWNER]     = ev_owner_change;
  end

  assign wr_status = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
  assign wr_enable = bus_wr && (bus_addr == ADDR_W'(OFS_ENABLE));
  assign clr_vec   = wr_status ? bus_wdata : '0;

  hc_irq_sticky #(.W(DATA_W), .IMPL(STAT_MASK)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec), .q_o(status)
  );

  hc_irq_wrap_cnt #(.W(CNT_W)) u_ovr_cnt (
    .clk(clk), .rst(rst), .inc_i(ev_sched_overrun), .cnt_o(sched_overrun_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      halt_q  <= 1'b0;
      sof_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_enable)    en_q   <= bus_wdata & EN_MASK;
      if (ev_sys_error) halt_q <= 1'b1;   // only reset releases
      sof_q <= ev_frame_start;
      irq_q <= en_q[B_MASTER] & (|(status & en_q & STAT_MASK));
      case (bus_addr)
        ADDR_W'(OFS_STATUS): rdata_q <= status;
        ADDR_W'(OFS_ENABLE): rdata_q <= en_q;
        ADDR_W'(OFS_COUNT):  rdata_q <= DATA_W'(sched_overrun_cnt);
        default:             rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata        = rdata_q;
  assign writeback_permit = ~status[B_DONEWB];
  assign sof_token_req    = sof_q;
  assign ctrl_halt        = halt_q;
  assign irq              = irq_q;

  a_r6_permit_drop: assert property (@(posedge clk) disable iff (rst)
    ev_donehead_written |=> !writeback_permit) else $error("R6 permit");
  a_r8_halt_set: assert property (@(posedge clk) disable iff (rst)
    ev_sys_error |=> ctrl_halt) else $error("R8 halt set");
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    ctrl_halt |=> ctrl_halt) else $error("R8 halt dropped");
  a_r5_sof_pulse: assert property (@(posedge clk) disable iff (rst)
    ev_frame_start |=> (sof_token_req && status[B_FRAME])) else $error("R5 sof");
  a_r9_master_off: assert property (@(posedge clk) disable iff (rst)
    !en_q[B_MASTER] |=> !irq) else $error("R9 master gate");
endmodule

// File: tb/hc_irq_status_tb.sv
`timescale 1ns/1ps
module hc_irq_status_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ev_so = 0, ev_dw = 0, ev_fs = 0, res_line = 0, sw_res = 0;
  logic ev_se = 0, ev_fw = 0, ev_pc = 0, ev_oc = 0;
  logic [1:0]  cnt;
  logic        permit, sof, halt, irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0;
  logic        rd_req_d = 1'b0;

  always #2 clk = ~clk;

  hc_irq_status u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_sched_overrun(ev_so), .ev_donehead_written(ev_dw),
    .ev_frame_start(ev_fs), .dev_resume_sig(res_line),
    .sw_resume_active(sw_res), .ev_sys_error(ev_se),
    .ev_frame_wrap(ev_fw), .ev_port_change(ev_pc), .ev_owner_change(ev_oc),
    .sched_overrun_cnt(cnt), .writeback_permit(permit),
    .sof_token_req(sof), .ctrl_halt(halt), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: read data is registered (R11)
  always @(posedge clk) rd_req_d <= rd_req;
  always @(negedge clk) begin
    if (rd_req_d) begin
      if (exp_q.size() == 0) check("R11 unexpected read", bus_rdata, 32'hx);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; rd_req = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    tick(); rd_req = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick(); bus_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(3); rst = 1'b0; tick();
    // R1 reset state, R2/R11 map
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 permit", {31'b0, permit}, 1);
    check("R1 halt", {31'b0, halt}, 0);
    check("R1 sof", {31'b0, sof}, 0);
    rd(0, 0, "R1 status reset");
    rd(1, 0, "R1 enable reset");
    rd(2, 0, "R1 count reset");
    rd(3, 0, "R2 unmapped offset");

    // R5 frame start
    ev_fs = 1; tick(); ev_fs = 0;
    check("R5 sof pulse", {31'b0, sof}, 1);
    tick();
    check("R5 sof one cycle", {31'b0, sof}, 0);
    rd(0, 32'h4, "R5 frame bit");

    // R2 write-1 clear, write-0 ignored
    wr(0, 32'h0);
    rd(0, 32'h4, "R2 write0 keeps bit");
    wr(0, 32'h4);
    rd(0, 32'h0, "R2 write1 clears");

    // R3 event and clear together
    ev_fs = 1; wr(0, 32'h4); ev_fs = 0;
    rd(0, 32'h4, "R3 set beats clear");
    wr(0, 32'h4);
    rd(0, 32'h0, "R3 later clear");

    // R4 overrun flag and wrapping count
    ev_so = 1; tick(3); ev_so = 0;
    rd(2, 32'd3, "R4 count three");
    rd(0, 32'h1, "R4 overrun bit");
    ev_so = 1; tick(); ev_so = 0;
    rd(2, 32'd0, "R4 count wrap");
    ev_so = 1; tick(); ev_so = 0;
    rd(2, 32'd1, "R4 count after wrap");
    check("R4 count port", {30'b0, cnt}, 1);
    wr(0, 32'h1);

    // R6 writeback hold-off
    ev_dw = 1; tick(); ev_dw = 0;
    check("R6 permit low", {31'b0, permit}, 0);
    tick(3);
    check("R6 permit held", {31'b0, permit}, 0);
    rd(0, 32'h2, "R6 writeback bit");
    wr(0, 32'h2);
    check("R6 permit released", {31'b0, permit}, 1);

    // R7 edge-only resume, software resume ignored
    res_line = 1; tick(4);
    rd(0, 32'h8, "R7 rise sets");
    wr(0, 32'h8); tick(3);
    rd(0, 32'h0, "R7 held level ignored");
    res_line = 0; tick(); sw_res = 1; res_line = 1; tick(2);
    rd(0, 32'h0, "R7 software resume ignored");
    sw_res = 0; tick(2);
    rd(0, 32'h0, "R7 no edge after software");
    res_line = 0; tick(); res_line = 1; tick();
    rd(0, 32'h8, "R7 second rise sets");
    res_line = 0; wr(0, 32'h8);

    // R9 enable mask and interrupt
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'hC000_007F, "R9 enable readback");
    check("R9 no flag no irq", {31'b0, irq}, 0);
    ev_fs = 1; tick(); ev_fs = 0; tick();
    check("R9 irq raised", {31'b0, irq}, 1);
    wr(1, 32'h0000_007F); tick();
    check("R9 master off", {31'b0, irq}, 0);
    wr(1, 32'h8000_0000); tick();
    check("R9 bit not enabled", {31'b0, irq}, 0);
    wr(1, 32'h8000_0004); tick();
    check("R9 bit enabled", {31'b0, irq}, 1);
    wr(0, 32'h4); tick();
    check("R9 cleared flag", {31'b0, irq}, 0);

    // R10 remaining flags, reserved bits
    ev_fw = 1; ev_pc = 1; ev_oc = 1; tick(); ev_fw = 0; ev_pc = 0; ev_oc = 0;
    rd(0, 32'h4000_0060, "R10 extra flags");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0, "R10 all cleared");

    // R8 system error halt
    ev_se = 1; tick(); ev_se = 0;
    check("R8 halt raised", {31'b0, halt}, 1);
    rd(0, 32'h10, "R8 error bit");
    wr(0, 32'h10);
    rd(0, 32'h0, "R8 error bit cleared");
    check("R8 halt after clear", {31'b0, halt}, 1);
    rst = 1; tick(2); rst = 0; tick();
    check("R8 halt reset", {31'b0, halt}, 0);
    rd(1, 0, "R1 enable after reset");

    tick(2);
    check("R11 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule